// File: doc/BRIEF.md
# PLL Configuration and Status Register Bank

This block holds the software-visible setup of a clock-synthesis PLL in a small microcontroller. It has six 8-bit registers at consecutive offsets on a plain synchronous bus. The bus has an offset, a write strobe, a read strobe and write data, and read data is returned combinationally. The register contents drive the PLL enable, the base-clock selection, a 12-bit feedback multiplier, an 8-bit VCO range value, a 2-bit power-of-two VCO range, and the automatic-bandwidth and acquisition mode controls. A lock indication from the PLL comes back through a two-stage synchronizer.

The registers are not independent of one another. Some bits are forced to a value, some fields refuse writes, and some bits read as zero, depending on the state of other fields. These rules stop software from changing the multiplier while the loop runs. They also stop it from selecting the PLL clock while the PLL is off or has no range programmed. While automatic mode is on, a change of the synchronized lock state sets an event flag. Reading the control register clears that flag. The flag and an enable bit together form an interrupt request.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset the six offsets read as follows: 0 (control) = 0x20, 1 (bandwidth) = 0x00, 2 (multiplier high) = 0x00, 3 (multiplier low) = 0x40, 4 (range) = 0x40, 5 (spare) = 0x01.
- R2: While automatic mode (offset 1 bit 7) is 0:
  - the interrupt enable (offset 0 bit 7) is held at 0 and ignores writes;
  - the event flag (offset 0 bit 6) reads 0;
  - the lock bit (offset 1 bit 6) reads 0.
- R3: While automatic mode is 1, a write leaves the acquisition bit (offset 1 bit 5) unchanged.
- R4: Base-clock select (offset 0 bit 4) is held at 0 whenever PLL-on (offset 0 bit 5) is 0 or the range value (offset 4) is zero.
- R5: While PLL-on is 1, writes to offsets 2, 3 and 4 leave the multiplier and the range value unchanged.
- R6: While base-clock select is 1, PLL-on stays 1 whatever is written.
- R7: The event flag behaves as follows:
  - it is set on the third clock edge after a change of the lock input, provided automatic mode is 1;
  - the lock bit follows the lock input after two edges;
  - a read strobe at offset 0 clears the flag;
  - a set and a clear on the same edge leave the flag set.
- R8: The interrupt request is high exactly when both the event flag and the interrupt enable are 1.
- R9: The following read as 0 and ignore writes: offset 0 bits 3:2, offset 1 bits 4:0, and offset 2 bits 7:4. Offsets 6 and 7 read 0x00. Offset 5 always reads 0x01. Writes to the flag and lock bits are ignored.
- R10: The output ports carry the stored field values, as follows:
  - the power-of-two range is offset 0 bits 1:0;
  - the multiplier is {offset 2 bits 3:0, offset 3};
  - the range value is offset 4;
  - automatic mode and acquisition mode are their bits in offset 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the event flag at offset 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| lock_in | input | 1 | Asynchronous lock indication from the PLL |
| pll_en | output | 1 | PLL enable |
| base_sel | output | 1 | Select PLL output as base clock |
| mult | output | 12 | Feedback multiplier |
| vco_range | output | 8 | VCO range value |
| vco_pow2 | output | 2 | VCO power-of-two range |
| auto_bw | output | 1 | Automatic bandwidth mode |
| acq_mode | output | 1 | Acquisition mode |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 data values across all eight offsets and compares every register and output after each write. Because the sweep keeps toggling PLL-on, base-clock select and automatic mode, each interlock meets both of its states.

Directed cases target specific failure modes:
- Selecting the PLL clock with a zero range value. A design that checks only PLL-on would then let base-clock select rise.
- Writing PLL-on to 0 in the same write that clears base-clock select. A design that evaluates the interlock on the wrong cycle would let PLL-on drop.
- Clearing automatic mode. A design that only masks the enable on output would keep a stale interrupt enable.

The lock path is checked one edge before and on the edge where the flag is due, so a missing or extra synchronizer stage shows up as a miscompare. A flag that a read fails to clear, or that is set without automatic mode, is also reported.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int MULT_W      = 12;
    localparam int MULT_HI_W   = MULT_W - DATA_W;
    localparam int RANGE_W     = 8;
    localparam int POW_W       = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTL   = 3'd0,
        OFS_BW    = 3'd1,
        OFS_MULH  = 3'd2,
        OFS_MULL  = 3'd3,
        OFS_RANGE = 3'd4,
        OFS_SPARE = 3'd5
    } reg_ofs_e;

    // stored control fields
    typedef struct packed {
        logic             irq_en;
        logic             pll_on;
        logic             base_sel;
        logic [POW_W-1:0] pow2;
    } ctl_t;

    // stored bandwidth fields
    typedef struct packed {
        logic auto_bw;
        logic acq;
    } bw_t;

    localparam ctl_t             CTL_RST   = '{irq_en: 1'b0, pll_on: 1'b1, base_sel: 1'b0, pow2: '0};
    localparam bw_t              BW_RST    = '{auto_bw: 1'b0, acq: 1'b0};
    localparam logic [MULT_W-1:0]  MULT_RST  = MULT_W'(12'h040);
    localparam logic [RANGE_W-1:0] RANGE_RST = RANGE_W'(8'h40);
    localparam logic [DATA_W-1:0]  SPARE_VAL = DATA_W'(8'h01);

    // bit positions decoded by software
    localparam int B_IE   = 7;
    localparam int B_FLAG = 6;
    localparam int B_ON   = 5;
    localparam int B_BCS  = 4;
    localparam int B_AUTO = 7;
    localparam int B_LOCK = 6;
    localparam int B_ACQ  = 5;

    function automatic logic [DATA_W-1:0] pack_ctl(ctl_t c, logic flag);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[B_IE]    = c.irq_en;
        v[B_FLAG]  = flag;
        v[B_ON]    = c.pll_on;
        v[B_BCS]   = c.base_sel;
        v[POW_W-1:0] = c.pow2;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_bw(bw_t b, logic lock_vis);
        logic [DATA_W-1:0] v;
        v         = '0;
        v[B_AUTO] = b.auto_bw;
        v[B_LOCK] = lock_vis;
        v[B_ACQ]  = b.acq;
        return v;
    endfunction

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
    parameter int STAGES = pll_cfg_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out,
    output logic toggled
);
    logic [STAGES-1:0] stg_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '0;
                else     stg_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '0;
                else     stg_q <= {stg_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stg_q[STAGES-1];
    end

    assign sync_out = stg_q[STAGES-1];
    assign toggled  = stg_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/pll_mode_regs.sv
module pll_mode_regs
    import pll_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic              wr_bw,
    input  logic              rd_ctl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              range_nz,
    input  logic              lock_toggle,
    output ctl_t              ctl,
    output bw_t               bw,
    output logic              flag
);
    ctl_t ctl_q, ctl_nxt;
    bw_t  bw_q,  bw_nxt;
    logic flag_q, flag_nxt;
    logic bcs_cand;

    always_comb begin
        bw_nxt = bw_q;
        if (wr_bw) begin
            bw_nxt.auto_bw = wdata[B_AUTO];
            // acquisition bit frozen while automatic mode is on
            if (!bw_q.auto_bw) bw_nxt.acq = wdata[B_ACQ];
        end

        ctl_nxt = ctl_q;
        if (wr_ctl) ctl_nxt.pow2 = wdata[POW_W-1:0];

        // base-clock select pins PLL-on high
        if (ctl_q.base_sel)  ctl_nxt.pll_on = 1'b1;
        else if (wr_ctl)     ctl_nxt.pll_on = wdata[B_ON];

        bcs_cand = wr_ctl ? wdata[B_BCS] : ctl_q.base_sel;
        ctl_nxt.base_sel = (ctl_nxt.pll_on && range_nz) ? bcs_cand : 1'b0;

        if (!bw_nxt.auto_bw)  ctl_nxt.irq_en = 1'b0;
        else if (wr_ctl)      ctl_nxt.irq_en = wdata[B_IE];

        if (!bw_nxt.auto_bw)                  flag_nxt = 1'b0;
        else if (lock_toggle && bw_q.auto_bw) flag_nxt = 1'b1;
        else if (rd_ctl)                      flag_nxt = 1'b0;
        else                                  flag_nxt = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_RST;
            bw_q   <= BW_RST;
            flag_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_nxt;
            bw_q   <= bw_nxt;
            flag_q <= flag_nxt;
        end
    end

    assign ctl  = ctl_q;
    assign bw   = bw_q;
    assign flag = flag_q;

    a_r2_enable_needs_auto: assert property (@(posedge clk) disable iff (rst)
        !bw_q.auto_bw |-> (!ctl_q.irq_en && !flag_q));

    a_r3_acq_frozen: assert property (@(posedge clk) disable iff (rst)
        bw_q.auto_bw |=> $stable(bw_q.acq));

    a_r4_bcs_gated: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.pll_on || !range_nz) |-> !ctl_q.base_sel);

    a_r6_on_held: assert property (@(posedge clk) disable iff (rst)
        ctl_q.base_sel |=> ctl_q.pll_on);

    a_r7_flag_sets: assert property (@(posedge clk) disable iff (rst)
        (bw_q.auto_bw && lock_toggle && !wr_bw) |=> flag_q);

endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs
    import pll_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_mulh,
    input  logic               wr_mull,
    input  logic               wr_range,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               frozen,
    output logic [MULT_W-1:0]  mult,
    output logic [RANGE_W-1:0] range_val
);
    logic [MULT_W-1:0]  mult_q;
    logic [RANGE_W-1:0] range_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_q  <= MULT_RST;
            range_q <= RANGE_RST;
        end else if (!frozen) begin
            if (wr_mulh)  mult_q[MULT_W-1:DATA_W] <= wdata[MULT_HI_W-1:0];
            if (wr_mull)  mult_q[DATA_W-1:0]      <= wdata;
            if (wr_range) range_q                 <= wdata[RANGE_W-1:0];
        end
    end

    assign mult      = mult_q;
    assign range_val = range_q;

    a_r5_prog_frozen: assert property (@(posedge clk) disable iff (rst)
        frozen |=> ($stable(mult_q) && $stable(range_q)));

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               lock_in,
    output logic               pll_en,
    output logic               base_sel,
    output logic [MULT_W-1:0]  mult,
    output logic [RANGE_W-1:0] vco_range,
    output logic [POW_W-1:0]   vco_pow2,
    output logic               auto_bw,
    output logic               acq_mode,
    output logic               irq
);
    ctl_t               ctl;
    bw_t                bw;
    logic               flag;
    logic               lock_s, lock_tog;
    logic [MULT_W-1:0]  mult_w;
    logic [RANGE_W-1:0] range_w;
    logic               wr_ctl, wr_bw, wr_mulh, wr_mull, wr_range, rd_ctl;

    assign wr_ctl   = bus_wr && (bus_addr == OFS_CTL);
    assign wr_bw    = bus_wr && (bus_addr == OFS_BW);
    assign wr_mulh  = bus_wr && (bus_addr == OFS_MULH);
    assign wr_mull  = bus_wr && (bus_addr == OFS_MULL);
    assign wr_range = bus_wr && (bus_addr == OFS_RANGE);
    assign rd_ctl   = bus_rd && (bus_addr == OFS_CTL);

    pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (lock_in),
        .sync_out (lock_s),
        .toggled  (lock_tog)
    );

    pll_mode_regs u_mode (
        .clk         (clk),
        .rst         (rst),
        .wr_ctl      (wr_ctl),
        .wr_bw       (wr_bw),
        .rd_ctl      (rd_ctl),
        .wdata       (bus_wdata),
        .range_nz    (|range_w),
        .lock_toggle (lock_tog),
        .ctl         (ctl),
        .bw          (bw),
        .flag        (flag)
    );

    pll_prog_regs u_prog (
        .clk       (clk),
        .rst       (rst),
        .wr_mulh   (wr_mulh),
        .wr_mull   (wr_mull),
        .wr_range  (wr_range),
        .wdata     (bus_wdata),
        .frozen    (ctl.pll_on),
        .mult      (mult_w),
        .range_val (range_w)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_CTL:   bus_rdata = pack_ctl(ctl, flag);
            OFS_BW:    bus_rdata = pack_bw(bw, lock_s && bw.auto_bw);
            OFS_MULH:  bus_rdata = DATA_W'(mult_w[MULT_W-1:DATA_W]);
            OFS_MULL:  bus_rdata = mult_w[DATA_W-1:0];
            OFS_RANGE: bus_rdata = DATA_W'(range_w);
            OFS_SPARE: bus_rdata = SPARE_VAL;
            default:   bus_rdata = '0;
        endcase
    end

    assign pll_en    = ctl.pll_on;
    assign base_sel  = ctl.base_sel;
    assign mult      = mult_w;
    assign vco_range = range_w;
    assign vco_pow2  = ctl.pow2;
    assign auto_bw   = bw.auto_bw;
    assign acq_mode  = bw.acq;
    assign irq       = flag && ctl.irq_en;

    a_r8_irq_needs_auto: assert property (@(posedge clk) disable iff (rst)
        irq |-> auto_bw);

    a_r6_sel_implies_on: assert property (@(posedge clk) disable iff (rst)
        base_sel |-> pll_en);

endmodule

// File: tb/tb_pll_cfg_regs.sv
module tb_pll_cfg_regs;
    import pll_cfg_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        lock_in = 1'b0;
    logic        pll_en, base_sel, auto_bw, acq_mode, irq;
    logic [11:0] mult;
    logic [7:0]  vco_range;
    logic [1:0]  vco_pow2;

    pll_cfg_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_in(lock_in),
        .pll_en(pll_en), .base_sel(base_sel), .mult(mult), .vco_range(vco_range),
        .vco_pow2(vco_pow2), .auto_bw(auto_bw), .acq_mode(acq_mode), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // reference model state
    logic m_ie = 0, m_flag = 0, m_on = 1, m_bcs = 0, m_auto = 0, m_acq = 0, m_lock = 0;
    logic [1:0]  m_pow = 0;
    logic [11:0] m_mult = 12'h040;
    logic [7:0]  m_vrs = 8'h40;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg(input int a);
        case (a)
            0: return {m_ie, m_flag & m_auto, m_on, m_bcs, 2'b00, m_pow};
            1: return {m_auto, m_lock & m_auto, m_acq, 5'b00000};
            2: return {4'h0, m_mult[11:8]};
            3: return m_mult[7:0];
            4: return m_vrs;
            5: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    task automatic peek(input int a, input string req);
        @(negedge clk);
        bus_addr = a[2:0];
        bus_rd = 1'b0;
        #1 chk(bus_rdata, exp_reg(a), req);
    endtask

    task automatic chk_outputs(input string req);
        chk({pll_en, base_sel, mult, vco_range, vco_pow2, auto_bw, acq_mode, irq},
            {m_on, m_bcs, m_mult, m_vrs, m_pow, m_auto, m_acq, m_ie & m_flag}, req);
    endtask

    task automatic bus_write(input int a, input logic [7:0] d);
        logic on_n;
        @(negedge clk);
        bus_addr = a[2:0];
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            0: begin
                on_n = m_bcs ? 1'b1 : d[5];
                m_bcs = (on_n && m_vrs != 0) ? d[4] : 1'b0;
                m_on = on_n;
                m_ie = m_auto ? d[7] : 1'b0;
                m_pow = d[1:0];
            end
            1: begin
                if (!m_auto) m_acq = d[5];
                m_auto = d[7];
                if (!m_auto) begin m_ie = 0; m_flag = 0; end
            end
            2: if (!m_on) m_mult[11:8] = d[3:0];
            3: if (!m_on) m_mult[7:0] = d;
            4: if (!m_on) m_vrs = d;
            default: ;
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        for (int a = 0; a < 6; a++) peek(a, "R1 reset value");
        chk_outputs("R1 reset outputs");

        bus_write(3, 8'h12);  peek(3, "R5 multiplier frozen while on");
        bus_write(4, 8'h00);  peek(4, "R5 range frozen while on");
        bus_write(0, 8'hE0);  peek(0, "R2 enable held clear without auto");
        bus_write(0, 8'h00);  bus_write(4, 8'h00);
        bus_write(0, 8'h30);  peek(0, "R4 base select blocked by zero range");
        bus_write(0, 8'h00);  bus_write(4, 8'h5A);
        bus_write(2, 8'hFB);  peek(2, "R9 upper nibble of multiplier high");
        bus_write(0, 8'h10);  peek(0, "R4 base select blocked while off");
        bus_write(0, 8'h3F);  peek(0, "R9 reserved control bits read zero");
        chk_outputs("R10 fields on outputs");
        bus_write(0, 8'h03);  peek(0, "R6 pll on held by base select");
        bus_write(1, 8'h80);  bus_write(1, 8'hA0);
        peek(1, "R3 acquisition frozen in auto");
        bus_write(1, 8'h00);  bus_write(1, 8'h7F);
        peek(1, "R9 bandwidth zero bits and lock write ignored");
        peek(5, "R9 spare register constant");
        peek(6, "R9 unused offset 6");
        peek(7, "R9 unused offset 7");

        // near-exhaustive sweep: every data value at every offset
        for (int d = 0; d < 256; d++) begin
            for (int a = 0; a < 8; a++) begin
                bus_write(a, d[7:0]);
                for (int r = 0; r < 8; r++) peek(r, "R2 R3 R4 R5 R6 R9 sweep");
                chk_outputs("R10 sweep outputs");
            end
        end

        // lock event path
        bus_write(1, 8'h80);
        bus_write(0, 8'h80);
        @(negedge clk);
        lock_in = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        m_lock = 1'b1;
        bus_addr = 3'd1;
        #1 chk(bus_rdata, exp_reg(1), "R7 lock bit after two stages");
        chk(irq, 1'b0, "R7 flag not yet set");
        @(posedge clk); #1;
        m_flag = 1'b1;
        bus_addr = 3'd0;
        #1 chk(bus_rdata, exp_reg(0), "R7 flag set on third edge");
        chk(irq, 1'b1, "R8 irq from flag and enable");
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        m_flag = 1'b0;
        peek(0, "R7 flag cleared by read");
        chk(irq, 1'b0, "R8 irq drops with flag");
        bus_write(1, 8'h00);
        @(negedge clk);
        lock_in = 1'b0;
        repeat (4) @(negedge clk);
        m_lock = 1'b0;
        peek(0, "R7 no flag without auto");
        peek(1, "R2 lock masked without auto");
        chk_outputs("R8 outputs after lock test");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule